// File: doc/BRIEF.md
# Multi-pattern LED animation sequencer

This block animates a row of eight LEDs in one of four run-time selectable patterns. Each LED has its own 8-bit brightness value, turned into light by a shared free-running PWM counter: an LED is lit in a cycle when the counter is below that LED's duty. A slow step tick, derived from the clock through a prescaler whose period a 4-bit speed switch sets, advances the animation. The four patterns are a heartbeat: a double pulse walking along the row. Breathing is a smooth rise and fall walking along the row. The one-way sweep fills the row from one end and then fades it out. The converging sweep fills from both ends toward the middle and then fades out.

Four one-cycle button pulses, already debounced, pick the pattern. A press restarts the chosen pattern from its first position with zero brightness and restarts the step prescaler. Pattern states are: heartbeat first peak (`ST_HB_PEAK1`), gap (`ST_HB_GAP`), second peak (`ST_HB_PEAK2`) and rest (`ST_HB_REST`). Breathing uses rise (`ST_BR_UP`) and fall (`ST_BR_DOWN`), and both sweeps use fill (`ST_FL_FILL`) and fade (`ST_FL_FADE`). The transitions, taken only on a step tick, are: PEAK1→GAP→PEAK2→REST, each after `HB_PHASE_STEPS` steps, and REST→PEAK1 with the LED pointer moved on. UP→DOWN happens when the next rise would exceed full scale, and DOWN→UP on the next LED when the level would drop below one ramp step. FILL→FADE happens when the fill is complete, and FADE→FILL when the level would drop below one ramp step. A button press jumps from any state to the entry state of the selected pattern.

Top module: `led_show_seq`

## Requirements
- R1: After a synchronous reset, the pattern is heartbeat in state PEAK1 with LED 0 at full duty (255), all other LEDs at duty 0, and the PWM counter at 0, so `leds` reads 8'b0000_0001 in the first cycle after reset.
- R2: The PWM counter counts up by one each clock and wraps from 255 to 0. LED i is driven high exactly when the counter is below LED i's duty, so duty 0 is always dark and duty 255 is dark only at count 255.
- R3: The animation advances once every (speed_sw + 1) × 2^STEP_SHIFT clock cycles, counted from reset or from the last button press. Two step ticks are never adjacent.
- R4: Heartbeat: only the LED under the pointer (starting at 0, rising, wrapping 7→0) has non-zero duty. It goes through PEAK1 (duty 255), GAP (0), PEAK2 (duty 128) and REST (0), each for HB_PHASE_STEPS steps, after which the pointer advances. During GAP and REST all LEDs are dark.
- R5: Breathing: the pointed LED's duty starts at 0 and rises by RAMP_STEP per step while it stays ≤ 255. It then falls by RAMP_STEP per step. When a fall would go below 0 the duty becomes 0 and the pointer moves to the next LED (wrapping).
- R6: One-way sweep: a count starts at 0 and grows by one per step. LEDs with index below the count are at duty 255. When the count equals 8, the next step makes all eight LEDs share a level of 255. That level then drops by RAMP_STEP per step until a drop would go below 0, when the count and level restart at 0.
- R7: Converging sweep: as R6, but LED i is at full duty when i < count or i ≥ 8 − count, and the fill completes at count 4.
- R8: btn_sel[0] selects heartbeat, btn_sel[1] breathing, btn_sel[2] the one-way sweep and btn_sel[3] the converging sweep. The lowest set bit wins if several are set. On the next clock the chosen pattern starts at its entry state with pointer, count, phase and level at 0. A press takes priority over a step tick in the same cycle. Without a press or a step tick, pattern and state hold.
- R9: In heartbeat and breathing, at most one LED is lit in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_sel | input | 4 | One-cycle pattern select pulses (bit 0 heartbeat, 1 breathing, 2 one-way sweep, 3 converging sweep) |
| speed_sw | input | SW_W (4) | Step-rate setting; 0 is fastest |
| leds | output | N_LEDS (8) | Active-high LED drive lines |

## Verification
Each pattern runs for several complete cycles of its animation at the fastest and slower switch settings, so both the step timing and the wrap of the LED pointer are seen. A mid-run switch change shows that a new rate takes effect at once. Button presses in the middle of a sweep or a breath show that position and level are cleared rather than carried over. A press of two buttons together tells the priority order apart from an OR of the selections. A reset in the middle of a run confirms the default pattern. Comparing the LED lines on every cycle with a behavioural model also checks the PWM threshold, because a duty off by one shows up as a mismatch at a single counter value.

// File: rtl/led_show_pkg.sv
package led_show_pkg;

    typedef enum logic [1:0] {
        PAT_HEART,
        PAT_BREATH,
        PAT_FLOW1,
        PAT_FLOW2
    } pattern_e;

    typedef enum logic [2:0] {
        ST_HB_PEAK1,
        ST_HB_GAP,
        ST_HB_PEAK2,
        ST_HB_REST,
        ST_BR_UP,
        ST_BR_DOWN,
        ST_FL_FILL,
        ST_FL_FADE
    } anim_state_e;

endpackage

// File: rtl/led_step_prescaler.sv
module led_step_prescaler #(
    parameter int SW_W       = 4,
    parameter int STEP_SHIFT = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [SW_W-1:0] rate,
    output logic            step_tick
);
    localparam int CNT_W = SW_W + STEP_SHIFT + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    // period = (rate + 1) << STEP_SHIFT, tick on its final cycle
    assign last_cnt  = ((CNT_W'(rate) + CNT_W'(1)) << STEP_SHIFT) - CNT_W'(1);
    assign step_tick = (cnt >= last_cnt);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (step_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/led_pwm_bank.sv
module led_pwm_bank #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0][DW-1:0] duty,
    output logic [DW-1:0]        pwm_cnt,
    output logic [N-1:0]         leds
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_cnt <= '0;
        end else begin
            pwm_cnt <= pwm_cnt + DW'(1);
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign leds[g] = (pwm_cnt < duty[g]);
    end

endmodule

// File: rtl/led_anim_fsm.sv
module led_anim_fsm
    import led_show_pkg::*;
#(
    parameter int N              = 8,
    parameter int DW             = 8,
    parameter int HB_PHASE_STEPS = 4,
    parameter int RAMP_STEP      = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           btn,
    input  logic                 step_tick,
    output logic                 btn_hit,
    output pattern_e             pattern,
    output anim_state_e          state,
    output logic [N-1:0][DW-1:0] duty
);
    localparam int IDX_W = $clog2(N + 1);
    localparam int PH_W  = $clog2(HB_PHASE_STEPS + 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HB_PHASE_STEPS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N - 1);
    localparam logic [IDX_W-1:0] IDX_ALL  = IDX_W'(N);
    localparam logic [IDX_W-1:0] IDX_HALF = IDX_W'(N / 2);
    localparam logic [DW-1:0]    FULL     = '1;
    localparam logic [DW-1:0]    HALF     = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0]    RAMP     = DW'(RAMP_STEP);
    localparam logic [DW-1:0]    RISE_MAX = FULL - RAMP;

    pattern_e          pat_n, sel;
    anim_state_e       st_n;
    logic [IDX_W-1:0]  idx, idx_n, idx_inc, fill_limit;
    logic [DW-1:0]     level, lvl_n;
    logic [PH_W-1:0]   phase, ph_n;

    assign btn_hit    = |btn;
    assign idx_inc    = (idx == IDX_LAST) ? '0 : idx + IDX_W'(1);
    assign fill_limit = (pattern == PAT_FLOW2) ? IDX_HALF : IDX_ALL;

    always_comb begin
        if (btn[0])      sel = PAT_HEART;
        else if (btn[1]) sel = PAT_BREATH;
        else if (btn[2]) sel = PAT_FLOW1;
        else             sel = PAT_FLOW2;
    end

    // next-state logic
    always_comb begin
        pat_n = pattern;
        st_n  = state;
        idx_n = idx;
        lvl_n = level;
        ph_n  = phase;
        if (btn_hit) begin
            pat_n = sel;
            idx_n = '0;
            lvl_n = '0;
            ph_n  = '0;
            unique case (sel)
                PAT_HEART:  st_n = ST_HB_PEAK1;
                PAT_BREATH: st_n = ST_BR_UP;
                default:    st_n = ST_FL_FILL;
            endcase
        end else if (step_tick) begin
            unique case (state)
                ST_HB_PEAK1, ST_HB_GAP, ST_HB_PEAK2, ST_HB_REST: begin
                    if (phase == PH_LAST) begin
                        ph_n = '0;
                        case (state)
                            ST_HB_PEAK1: st_n = ST_HB_GAP;
                            ST_HB_GAP:   st_n = ST_HB_PEAK2;
                            ST_HB_PEAK2: st_n = ST_HB_REST;
                            default: begin
                                st_n  = ST_HB_PEAK1;
                                idx_n = idx_inc;
                            end
                        endcase
                    end else begin
                        ph_n = phase + PH_W'(1);
                    end
                end
                ST_BR_UP: begin
                    if (level > RISE_MAX) st_n = ST_BR_DOWN;
                    else                  lvl_n = level + RAMP;
                end
                ST_BR_DOWN: begin
                    if (level < RAMP) begin
                        lvl_n = '0;
                        st_n  = ST_BR_UP;
                        idx_n = idx_inc;
                    end else begin
                        lvl_n = level - RAMP;
                    end
                end
                ST_FL_FILL: begin
                    if (idx == fill_limit) begin
                        st_n  = ST_FL_FADE;
                        lvl_n = FULL;
                    end else begin
                        idx_n = idx + IDX_W'(1);
                    end
                end
                ST_FL_FADE: begin
                    if (level < RAMP) begin
                        lvl_n = '0;
                        idx_n = '0;
                        st_n  = ST_FL_FILL;
                    end else begin
                        lvl_n = level - RAMP;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            pattern <= PAT_HEART;
            state   <= ST_HB_PEAK1;
            idx     <= '0;
            level   <= '0;
            phase   <= '0;
        end else begin
            pattern <= pat_n;
            state   <= st_n;
            idx     <= idx_n;
            level   <= lvl_n;
            phase   <= ph_n;
        end
    end

    // outputs: per-LED duty
    always_comb begin
        for (int i = 0; i < N; i++) begin
            duty[i] = '0;
            unique case (state)
                ST_HB_PEAK1: if (IDX_W'(i) == idx) duty[i] = FULL;
                ST_HB_PEAK2: if (IDX_W'(i) == idx) duty[i] = HALF;
                ST_BR_UP, ST_BR_DOWN: if (IDX_W'(i) == idx) duty[i] = level;
                ST_FL_FILL: begin
                    if ((IDX_W'(i) < idx) ||
                        ((pattern == PAT_FLOW2) && (IDX_W'(i) >= IDX_ALL - idx)))
                        duty[i] = FULL;
                end
                ST_FL_FADE: duty[i] = level;
                default: duty[i] = '0;
            endcase
        end
    end

endmodule

// File: rtl/led_show_seq.sv
module led_show_seq
    import led_show_pkg::*;
#(
    parameter int N_LEDS         = 8,
    parameter int SW_W           = 4,
    parameter int DUTY_W         = 8,
    parameter int STEP_SHIFT     = 16,
    parameter int HB_PHASE_STEPS = 4,
    parameter int RAMP_STEP      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        btn_sel,
    input  logic [SW_W-1:0]   speed_sw,
    output logic [N_LEDS-1:0] leds
);
    logic                          step_tick;
    logic                          btn_hit;
    pattern_e                      pattern;
    anim_state_e                   state;
    logic [N_LEDS-1:0][DUTY_W-1:0] duty;
    logic [DUTY_W-1:0]             pwm_cnt;

    led_step_prescaler #(
        .SW_W       (SW_W),
        .STEP_SHIFT (STEP_SHIFT)
    ) u_presc (
        .clk       (clk),
        .rst       (rst),
        .restart   (btn_hit),
        .rate      (speed_sw),
        .step_tick (step_tick)
    );

    led_anim_fsm #(
        .N              (N_LEDS),
        .DW             (DUTY_W),
        .HB_PHASE_STEPS (HB_PHASE_STEPS),
        .RAMP_STEP      (RAMP_STEP)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .btn       (btn_sel),
        .step_tick (step_tick),
        .btn_hit   (btn_hit),
        .pattern   (pattern),
        .state     (state),
        .duty      (duty)
    );

    led_pwm_bank #(
        .N  (N_LEDS),
        .DW (DUTY_W)
    ) u_pwm (
        .clk     (clk),
        .rst     (rst),
        .duty    (duty),
        .pwm_cnt (pwm_cnt),
        .leds    (leds)
    );

endmodule

// File: rtl/led_show_chk.sv
module led_show_chk
    import led_show_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    btn_sel,
    input logic [N-1:0]  leds,
    input pattern_e      pattern,
    input anim_state_e   state,
    input logic          step_tick,
    input logic [DW-1:0] pwm_cnt
);
    // R1
    reset_default_chk: assert property (@(posedge clk)
        rst |=> (pattern == PAT_HEART && state == ST_HB_PEAK1 && pwm_cnt == '0));

    // R2
    pwm_count_chk: assert property (@(posedge clk) disable iff (rst)
        !btn_sel[3] || btn_sel[3] |=> pwm_cnt == DW'($past(pwm_cnt) + 1'b1));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        step_tick |=> !step_tick);

    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_tick && btn_sel == 4'b0000) |=> ($stable(state) && $stable(pattern)));

    // R8
    sweep_select_chk: assert property (@(posedge clk) disable iff (rst)
        (btn_sel[2] && !btn_sel[1] && !btn_sel[0]) |=> (pattern == PAT_FLOW1 && state == ST_FL_FILL));

    // R9
    single_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (pattern == PAT_HEART || pattern == PAT_BREATH) |-> $countones(leds) <= 1);

    // R4
    hb_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HB_GAP || state == ST_HB_REST) |-> leds == '0);

endmodule

bind led_show_seq led_show_chk #(.N(N_LEDS), .DW(DUTY_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .btn_sel   (btn_sel),
    .leds      (leds),
    .pattern   (pattern),
    .state     (state),
    .step_tick (step_tick),
    .pwm_cnt   (pwm_cnt)
);

// File: tb/led_show_seq_tb.sv
module led_show_seq_tb;
    localparam int SHIFT = 2;
    localparam int HBP   = 4;
    localparam int RAMP  = 32;

    // model state codes (bench's own)
    localparam int M_P1 = 0, M_GAP = 1, M_P2 = 2, M_REST = 3;
    localparam int M_UP = 4, M_DN = 5, M_FILL = 6, M_FADE = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] btn = 4'b0;
    logic [3:0] sw  = 4'd0;
    logic [7:0] leds;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    int m_pat, m_st, m_idx, m_lvl, m_ph, m_pwm, m_cnt;
    bit m_after_rst, m_after_btn;

    led_show_seq #(
        .STEP_SHIFT     (SHIFT),
        .HB_PHASE_STEPS (HBP),
        .RAMP_STEP      (RAMP)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .btn_sel  (btn),
        .speed_sw (sw),
        .leds     (leds)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    always @(posedge clk) begin
        bit tick;
        if (rst) begin
            m_pat = 0; m_st = M_P1; m_idx = 0; m_lvl = 0; m_ph = 0;
            m_pwm = 0; m_cnt = 0; m_after_rst = 1; m_after_btn = 0;
        end else begin
            m_after_rst = 0;
            m_after_btn = (btn != 0);
            tick  = (m_cnt >= ((int'(sw) + 1) * (1 << SHIFT)) - 1);
            m_pwm = (m_pwm + 1) % 256;
            if (btn != 0) begin
                m_pat = btn[0] ? 0 : btn[1] ? 1 : btn[2] ? 2 : 3;
                m_st  = (m_pat == 0) ? M_P1 : (m_pat == 1) ? M_UP : M_FILL;
                m_idx = 0; m_lvl = 0; m_ph = 0; m_cnt = 0;
            end else begin
                m_cnt = tick ? 0 : m_cnt + 1;
                if (tick) begin
                    if (m_st <= M_REST) begin
                        m_ph++;
                        if (m_ph == HBP) begin
                            m_ph = 0;
                            if (m_st == M_REST) begin
                                m_st = M_P1; m_idx = (m_idx + 1) % 8;
                            end else m_st++;
                        end
                    end else if (m_st == M_UP) begin
                        if (m_lvl + RAMP > 255) m_st = M_DN;
                        else m_lvl += RAMP;
                    end else if (m_st == M_DN) begin
                        if (m_lvl - RAMP < 0) begin
                            m_lvl = 0; m_st = M_UP; m_idx = (m_idx + 1) % 8;
                        end else m_lvl -= RAMP;
                    end else if (m_st == M_FILL) begin
                        if (m_idx == ((m_pat == 3) ? 4 : 8)) begin
                            m_st = M_FADE; m_lvl = 255;
                        end else m_idx++;
                    end else begin
                        if (m_lvl - RAMP < 0) begin
                            m_lvl = 0; m_idx = 0; m_st = M_FILL;
                        end else m_lvl -= RAMP;
                    end
                end
            end
        end
    end

    function automatic logic [7:0] model_leds();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            int d;
            d = 0;
            case (m_st)
                M_P1:       if (i == m_idx) d = 255;
                M_P2:       if (i == m_idx) d = 128;
                M_UP, M_DN: if (i == m_idx) d = m_lvl;
                M_FILL:     if (i < m_idx || (m_pat == 3 && i >= 8 - m_idx)) d = 255;
                M_FADE:     d = m_lvl;
                default:    d = 0;
            endcase
            r[i] = (m_pwm < d);
        end
        return r;
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] exp_l;
            string tag;
            exp_l = model_leds();
            if (m_after_rst)      tag = "R1";
            else if (m_after_btn) tag = "R8";
            else case (m_pat)
                0:       tag = "R2 R3 R4 R9";
                1:       tag = "R2 R3 R5 R9";
                2:       tag = "R2 R3 R6";
                default: tag = "R2 R3 R7";
            endcase
            n_cmp++;
            if (leds !== exp_l) begin
                n_bad++;
                $display("FAIL %s: leds=%b expected=%b at %0t", tag, leds, exp_l, $time);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic [3:0] b);
        @(negedge clk) btn = b;
        @(negedge clk) btn = 4'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        run(700);                 // heartbeat, fastest (R4)
        sw = 4'd3;  run(1100);    // slower step (R3)
        sw = 4'd0;
        press(4'b0010); run(1300);  // breathing (R5)
        sw = 4'd1;
        press(4'b0100); run(900);   // one-way sweep (R6)
        press(4'b0100); run(300);   // restart mid-sweep (R8)
        sw = 4'd0;
        press(4'b1000); run(600);   // converging sweep (R7)
        press(4'b0110); run(300);   // priority: breathing wins (R8)
        press(4'b1100); run(150);   // priority: one-way wins (R8)
        sw = 4'd15;
        press(4'b0001); run(2500);  // heartbeat, slowest (R3 R4)
        sw = 4'd2;  run(400);       // rate change mid-run (R3)
        press(4'b1000); run(100);
        @(negedge clk) rst = 1'b1;  // reset mid-run (R1)
        run(3);
        rst = 1'b0;
        run(200);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            finish_run();
        end
    end

endmodule